// File: doc/BRIEF.md
# Codec Register Setup Sequencer

This block is a write-only two-wire bus master that configures an audio codec once the chip is out of reset. A one-cycle request on `startReq` makes it send ten register writes in a fixed order. Each write is its own bus transaction. A transaction opens with a start condition and then carries three bytes: the device write address, the register number and the data value. The slave must acknowledge every byte.

Both bus lines are open drain. The block only ever asks for a line to be pulled low. Otherwise it leaves the line released, and the external pull-up makes it read high. Every bus event is built from a timed phase of a fixed number of system clocks. A data bit takes three phases. The acknowledge check uses two windows: a short one in which the slave must grab SDA, and a longer one in which it must let SDA go again. If either window passes without the expected level, the whole sequence stops at once with both lines released and an error flag raised. A clean run ends with a one-cycle done pulse. No stop condition is sent at any time.

Top module: `codec_cfg_seq`

## Requirements
- R1: After reset, and while no sequence is running, both line outputs are 0 (released), and `cfgDone` and `cfgError` are 0.
- R2: Each transaction opens with a start condition. SDA is pulled low while SCL is released. SCL is pulled low exactly 32 clocks later.
- R3: Bytes go out MSB first. A 1 bit releases SDA and a 0 bit pulls it low. SDA changes only while SCL is low. Every bit and acknowledge clock keeps SCL released for exactly 32 clocks.
- R4: The ten transactions carry the bytes 0x34, register, data. The register:data pairs are sent in this order: 0C:02, 0E:03, 00:17, 02:17, 04:79, 06:79, 0A:00, 08:12, 10:A0, 12:01.
- R5: If SDA is not seen low during the one phase that follows the eighth bit, the sequence aborts. `cfgError` rises, both lines are released, no further byte is clocked and no done pulse appears.
- R6: After the acknowledge clock and one idle phase, the slave has 128 clocks to release SDA. A release within that window lets the sequence go on. A slave that holds SDA beyond the window causes the abort of R5.
- R7: No stop condition is ever generated. SDA never goes from low to high while SCL stays released.
- R8: `cfgDone` is high for exactly one cycle after the final write completes. `cfgError` stays set until the next `startReq`, which clears it.
- R9: A `startReq` that arrives while a sequence is running is ignored, and the running sequence completes unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| startReq | input | 1 | Launches the write list when idle |
| sdaIn | input | 1 | Sensed level of the SDA line |
| sclPullLow | output | 1 | 1 pulls SCL low, 0 releases it |
| sdaPullLow | output | 1 | 1 pulls SDA low, 0 releases it |
| cfgDone | output | 1 | One-cycle pulse after the last write |
| cfgError | output | 1 | Sticky flag for a missing acknowledge or release |

## Verification
Both line outputs are registered. Every line event therefore appears one clock after the phase counter starts it, and the distance between two events is exactly one phase count. The slave model measures the bus at the falling clock edge, so it counts start-to-SCL-low gaps and SCL-high widths directly as 32. `cfgError` and `cfgDone` rise on the clock edge that closes the failing window or the final release window. The bench waits for them by polling at falling edges and takes a bounded number of cycles for each scenario. Line release after an abort is sampled a few cycles later, which covers the one-cycle lag of the output registers.

// File: rtl/codec_cfg_pkg.sv
package codec_cfg_pkg;

  localparam int ENTRY_COUNT = 10;
  localparam logic [7:0] DEV_WRITE_ADDR = 8'h34;

  typedef enum logic [1:0] {
    SDA_RELEASE,
    SDA_LOW,
    SDA_BIT
  } sdaMode_t;

  typedef struct packed {
    logic     clrTimer;
    logic     loadFirst;
    logic     loadNext;
    logic     shiftBit;
    logic     sclLow;
    sdaMode_t sdaMode;
  } strobe_t;

  // register number in [15:8], value in [7:0]; order matters to the codec
  function automatic logic [15:0] cfgWord(input logic [7:0] idx);
    case (idx)
      8'd0:    cfgWord = 16'h0C02;
      8'd1:    cfgWord = 16'h0E03;
      8'd2:    cfgWord = 16'h0017;
      8'd3:    cfgWord = 16'h0217;
      8'd4:    cfgWord = 16'h0479;
      8'd5:    cfgWord = 16'h0679;
      8'd6:    cfgWord = 16'h0A00;
      8'd7:    cfgWord = 16'h0812;
      8'd8:    cfgWord = 16'h10A0;
      default: cfgWord = 16'h1201;
    endcase
  endfunction

endpackage

// File: rtl/cfg_datapath.sv
module cfg_datapath
  import codec_cfg_pkg::*;
#(
  parameter int PHASE_CLKS   = 32,
  parameter int RELEASE_CLKS = 128
) (
  input  logic    clk,
  input  logic    rstN,
  input  strobe_t stb,
  output logic    phaseEnd,
  output logic    relEnd,
  output logic    timerZero,
  output logic    lastBit,
  output logic    lastByte,
  output logic    lastEntry,
  output logic    sclPullLow,
  output logic    sdaPullLow
);

  localparam int LIMIT   = (PHASE_CLKS > RELEASE_CLKS) ? PHASE_CLKS : RELEASE_CLKS;
  localparam int CNT_W   = $clog2(LIMIT);
  localparam int ENTRY_W = $clog2(ENTRY_COUNT);

  logic [CNT_W-1:0]   timer;
  logic [7:0]         shiftReg;
  logic [2:0]         bitIdx;
  logic [1:0]         byteIdx;
  logic [ENTRY_W-1:0] entryIdx;
  logic [15:0]        word;

  assign word      = cfgWord(8'(entryIdx));
  assign phaseEnd  = (timer == CNT_W'(PHASE_CLKS - 1));
  assign relEnd    = (timer == CNT_W'(RELEASE_CLKS - 1));
  assign timerZero = (timer == '0);
  assign lastBit   = (bitIdx == 3'd7);
  assign lastByte  = (byteIdx == 2'd2);
  assign lastEntry = (entryIdx == ENTRY_W'(ENTRY_COUNT - 1));

  always_ff @(posedge clk) begin
    if (!rstN) timer <= '0;
    else if (stb.clrTimer) timer <= '0;
    else timer <= timer + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg <= '0;
      bitIdx   <= '0;
      byteIdx  <= '0;
      entryIdx <= '0;
    end else if (stb.loadFirst) begin
      shiftReg <= DEV_WRITE_ADDR;
      bitIdx   <= '0;
      byteIdx  <= '0;
      entryIdx <= '0;
    end else if (stb.loadNext) begin
      bitIdx <= '0;
      if (lastByte) begin
        byteIdx  <= '0;
        entryIdx <= entryIdx + 1'b1;
        shiftReg <= DEV_WRITE_ADDR;
      end else begin
        byteIdx  <= byteIdx + 1'b1;
        shiftReg <= (byteIdx == 2'd0) ? word[15:8] : word[7:0];
      end
    end else if (stb.shiftBit) begin
      shiftReg <= {shiftReg[6:0], 1'b0};
      bitIdx   <= bitIdx + 1'b1;
    end
  end

  // registered line drivers: no combinational glitch reaches the bus
  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclPullLow <= 1'b0;
      sdaPullLow <= 1'b0;
    end else begin
      sclPullLow <= stb.sclLow;
      sdaPullLow <= (stb.sdaMode == SDA_LOW) ||
                    ((stb.sdaMode == SDA_BIT) && !shiftReg[7]);
    end
  end

  // R7: SDA is never released while SCL stays high
  a_r7_no_stop: assert property (@(posedge clk) disable iff (!rstN)
    (!sclPullLow && !$past(sclPullLow)) |-> !$fell(sdaPullLow));

endmodule

// File: rtl/cfg_ctrl.sv
module cfg_ctrl
  import codec_cfg_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    startReq,
  input  logic    sdaIn,
  input  logic    phaseEnd,
  input  logic    relEnd,
  input  logic    timerZero,
  input  logic    lastBit,
  input  logic    lastByte,
  input  logic    lastEntry,
  output strobe_t stb,
  output logic    cfgDone,
  output logic    cfgError
);

  typedef enum logic [3:0] {
    IDLE, ST_REL, ST_SDA, ST_SCL,
    BIT_SET, BIT_HIGH, BIT_LOW,
    ACK_WAIT, ACK_HIGH, ACK_LOW, ACK_IDLE, ACK_REL
  } state_t;

  state_t state, nextState;
  logic   ackSeen, goDone, goErr, clrErr;

  always_comb begin
    nextState   = state;
    stb         = '0;
    stb.sdaMode = SDA_RELEASE;
    goDone      = 1'b0;
    goErr       = 1'b0;
    clrErr      = 1'b0;
    case (state)
      IDLE: begin
        stb.clrTimer = 1'b1;
        if (startReq) begin
          nextState     = ST_REL;
          stb.loadFirst = 1'b1;
          clrErr        = 1'b1;
        end
      end
      ST_REL: if (phaseEnd) nextState = ST_SDA;
      ST_SDA: begin
        stb.sdaMode = SDA_LOW;
        if (phaseEnd) nextState = ST_SCL;
      end
      ST_SCL: begin
        stb.sdaMode = SDA_LOW;
        stb.sclLow  = 1'b1;
        if (phaseEnd) nextState = BIT_SET;
      end
      BIT_SET: begin
        stb.sdaMode = SDA_BIT;
        stb.sclLow  = 1'b1;
        if (phaseEnd) nextState = BIT_HIGH;
      end
      BIT_HIGH: begin
        stb.sdaMode = SDA_BIT;
        if (phaseEnd) nextState = BIT_LOW;
      end
      BIT_LOW: begin
        stb.sdaMode = SDA_BIT;
        stb.sclLow  = 1'b1;
        if (phaseEnd) begin
          if (lastBit) nextState = ACK_WAIT;
          else begin
            nextState    = BIT_SET;
            stb.shiftBit = 1'b1;
          end
        end
      end
      ACK_WAIT: begin
        stb.sclLow = 1'b1;
        if (phaseEnd) begin
          if (ackSeen || !sdaIn) nextState = ACK_HIGH;
          else goErr = 1'b1;
        end
      end
      ACK_HIGH: if (phaseEnd) nextState = ACK_LOW;
      ACK_LOW: begin
        stb.sclLow = 1'b1;
        if (phaseEnd) nextState = ACK_IDLE;
      end
      ACK_IDLE: begin
        stb.sclLow = 1'b1;
        if (phaseEnd) nextState = ACK_REL;
      end
      ACK_REL: begin
        stb.sclLow = 1'b1;
        if (sdaIn) begin
          if (lastByte && lastEntry) goDone = 1'b1;
          else begin
            stb.loadNext = 1'b1;
            nextState    = lastByte ? ST_REL : BIT_SET;
          end
        end else if (relEnd) goErr = 1'b1;
      end
      default: nextState = IDLE;
    endcase
    if (goErr || goDone) nextState = IDLE;
    if (nextState != state) stb.clrTimer = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= IDLE;
      ackSeen  <= 1'b0;
      cfgDone  <= 1'b0;
      cfgError <= 1'b0;
    end else begin
      state   <= nextState;
      cfgDone <= goDone;
      // first cycle of the window still shows the old registered bit
      if (state != ACK_WAIT) ackSeen <= 1'b0;
      else if (!sdaIn && !timerZero) ackSeen <= 1'b1;
      if (goErr) cfgError <= 1'b1;
      else if (clrErr) cfgError <= 1'b0;
    end
  end

  // R5: an empty acknowledge window ends the run with the error flag
  a_r5_ack_abort: assert property (@(posedge clk) disable iff (!rstN)
    (state == ACK_WAIT && phaseEnd && !ackSeen && sdaIn) |=> (cfgError && state == IDLE));

  // R6: SDA still held at the end of the release window ends the run
  a_r6_release_timeout: assert property (@(posedge clk) disable iff (!rstN)
    (state == ACK_REL && relEnd && !sdaIn) |=> (cfgError && state == IDLE));

  // R8: completion is a single-cycle pulse and never coincides with an error
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    cfgDone |=> !cfgDone);

  a_r8_done_clean: assert property (@(posedge clk) disable iff (!rstN)
    cfgDone |-> !cfgError);

endmodule

// File: rtl/codec_cfg_seq.sv
module codec_cfg_seq
  import codec_cfg_pkg::*;
#(
  parameter int PHASE_CLKS   = 32,
  parameter int RELEASE_CLKS = 128
) (
  input  logic clk,
  input  logic rstN,
  input  logic startReq,
  input  logic sdaIn,
  output logic sclPullLow,
  output logic sdaPullLow,
  output logic cfgDone,
  output logic cfgError
);

  strobe_t stb;
  logic    phaseEnd, relEnd, timerZero, lastBit, lastByte, lastEntry;

  cfg_ctrl i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .startReq  (startReq),
    .sdaIn     (sdaIn),
    .phaseEnd  (phaseEnd),
    .relEnd    (relEnd),
    .timerZero (timerZero),
    .lastBit   (lastBit),
    .lastByte  (lastByte),
    .lastEntry (lastEntry),
    .stb       (stb),
    .cfgDone   (cfgDone),
    .cfgError  (cfgError)
  );

  cfg_datapath #(
    .PHASE_CLKS   (PHASE_CLKS),
    .RELEASE_CLKS (RELEASE_CLKS)
  ) i_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .phaseEnd   (phaseEnd),
    .relEnd     (relEnd),
    .timerZero  (timerZero),
    .lastBit    (lastBit),
    .lastByte   (lastByte),
    .lastEntry  (lastEntry),
    .sclPullLow (sclPullLow),
    .sdaPullLow (sdaPullLow)
  );

endmodule

// File: tb/test_codec_cfg_seq.sv
module test_codec_cfg_seq;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startReq = 1'b0;
  logic sclPullLow, sdaPullLow, cfgDone, cfgError;
  logic slaveLow = 1'b0;
  logic sclLine, sdaLine;

  assign sclLine = !sclPullLow;
  assign sdaLine = !(sdaPullLow || slaveLow);

  always #5 clk = ~clk;

  codec_cfg_seq i_codec_cfg_seq (
    .clk        (clk),
    .rstN       (rstN),
    .startReq   (startReq),
    .sdaIn      (sdaLine),
    .sclPullLow (sclPullLow),
    .sdaPullLow (sdaPullLow),
    .cfgDone    (cfgDone),
    .cfgError   (cfgError)
  );

  int compared = 0;
  int mismatched = 0;

  // R4 write list: register in [15:8], data in [7:0]
  logic [15:0] pairs [10] = '{16'h0C02, 16'h0E03, 16'h0017, 16'h0217, 16'h0479,
                              16'h0679, 16'h0A00, 16'h0812, 16'h10A0, 16'h1201};

  // open-drain slave model
  bit   ackEn = 1'b1;
  int   holdExtra = 0;
  int   bitCnt = 0, starts = 0, stops = 0, byteCnt = 0;
  int   badHigh = 0, badGap = 0, doneCnt = 0;
  int   highCnt = 0, gapCnt = 0, relCnt = 0;
  bit   inGap = 1'b0;
  logic prevScl = 1'b1, prevSda = 1'b1;
  logic [7:0] shifter = '0;
  logic [7:0] got [32];

  always @(negedge clk) begin
    if (cfgDone) doneCnt++;
    if (relCnt > 0) begin
      relCnt--;
      if (relCnt == 0) slaveLow = 1'b0;
    end
    if (prevScl && sclLine && prevSda && !sdaLine) begin
      starts++; bitCnt = 0; gapCnt = 0; inGap = 1'b1;
    end else if (prevScl && sclLine && !prevSda && sdaLine) begin
      stops++;
    end
    if (!prevScl && sclLine) begin
      highCnt = 1;
      if (bitCnt < 8) shifter = {shifter[6:0], sdaLine};
      bitCnt++;
      if (bitCnt == 8 && byteCnt < 32) begin
        got[byteCnt] = shifter;
        byteCnt++;
      end
    end else if (sclLine) begin
      highCnt++; gapCnt++;
    end
    if (prevScl && !sclLine) begin
      if (bitCnt == 0 && inGap) begin
        if (gapCnt != 32) badGap++;
        inGap = 1'b0;
      end else if (bitCnt != 0 && highCnt != 32) badHigh++;
      if (bitCnt == 8 && ackEn) slaveLow = 1'b1;
      else if (bitCnt == 9) begin
        bitCnt = 0;
        if (holdExtra == 0) slaveLow = 1'b0;
        else relCnt = holdExtra;
      end
    end
    prevScl = sclLine;
    prevSda = sdaLine;
  end

  task automatic check(input bit ok, input string req, input int act, input int expv,
                       input string what);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic clearSlave(input bit ack, input int hold);
    @(negedge clk);
    ackEn = ack; holdExtra = hold;
    starts = 0; stops = 0; byteCnt = 0; badHigh = 0; badGap = 0; doneCnt = 0;
  endtask

  task automatic pulseStart();
    @(negedge clk) startReq = 1'b1;
    @(negedge clk) startReq = 1'b0;
  endtask

  task automatic waitEnd();
    for (int i = 0; i < 40000; i++) begin
      @(negedge clk);
      if (doneCnt > 0 || cfgError) break;
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic checkFullRun(input string req);
    check(doneCnt == 1, "R8", doneCnt, 1, {req, " done pulse count"});
    check(cfgError == 1'b0, req, cfgError, 0, "error after clean run");
    check(byteCnt == 30, "R4", byteCnt, 30, "bytes captured");
    check(starts == 10, "R2", starts, 10, "start conditions");
    check(badGap == 0, "R2", badGap, 0, "start-to-SCL-low gaps not 32");
    check(badHigh == 0, "R3", badHigh, 0, "SCL high widths not 32");
    check(stops == 0, "R7", stops, 0, "stop conditions");
    for (int e = 0; e < 10; e++) begin
      check(got[3*e] == 8'h34, "R4", got[3*e], 8'h34, "address byte");
      check(got[3*e+1] == pairs[e][15:8], "R4", got[3*e+1], pairs[e][15:8], "register byte");
      check(got[3*e+2] == pairs[e][7:0], "R4", got[3*e+2], pairs[e][7:0], "data byte");
    end
    check(!sclPullLow && !sdaPullLow, "R1", {sclPullLow, sdaPullLow}, 0, "lines idle after run");
  endtask

  task automatic testReset();
    check(!sclPullLow && !sdaPullLow, "R1", {sclPullLow, sdaPullLow}, 0, "lines at reset");
    check(!cfgDone && !cfgError, "R1", {cfgDone, cfgError}, 0, "flags at reset");
  endtask

  task automatic testFullRun();
    clearSlave(1'b1, 0);
    pulseStart();
    waitEnd();
    checkFullRun("R3");
  endtask

  task automatic testBusyStart();
    clearSlave(1'b1, 0);
    pulseStart();
    repeat (5000) @(negedge clk);
    pulseStart();   // R9: must be ignored
    waitEnd();
    check(byteCnt == 30, "R9", byteCnt, 30, "bytes with start while busy");
    check(starts == 10, "R9", starts, 10, "starts with start while busy");
    check(doneCnt == 1, "R9", doneCnt, 1, "done pulses with start while busy");
  endtask

  task automatic testNoAck();
    clearSlave(1'b0, 0);
    pulseStart();
    waitEnd();
    check(cfgError == 1'b1, "R5", cfgError, 1, "error on missing ack");
    check(doneCnt == 0, "R5", doneCnt, 0, "done on missing ack");
    check(byteCnt == 1, "R5", byteCnt, 1, "bytes clocked before abort");
    check(!sclPullLow && !sdaPullLow, "R5", {sclPullLow, sdaPullLow}, 0, "lines after abort");
    repeat (300) @(negedge clk);
    check(cfgError == 1'b1, "R8", cfgError, 1, "error held while idle");
    check(byteCnt == 1, "R5", byteCnt, 1, "no bytes while aborted");
  endtask

  task automatic testRestartClears();
    clearSlave(1'b1, 0);
    pulseStart();
    check(cfgError == 1'b0, "R8", cfgError, 1, "error cleared by new start");
    waitEnd();
    checkFullRun("R8");
  endtask

  task automatic testSlowRelease();
    clearSlave(1'b1, 100);
    pulseStart();
    waitEnd();
    check(cfgError == 1'b0, "R6", cfgError, 0, "late release within window");
    check(doneCnt == 1, "R6", doneCnt, 1, "done with late release");
    check(byteCnt == 30, "R6", byteCnt, 30, "bytes with late release");
  endtask

  task automatic testStuckRelease();
    clearSlave(1'b1, 300);
    pulseStart();
    waitEnd();
    check(cfgError == 1'b1, "R6", cfgError, 1, "error when SDA held too long");
    check(doneCnt == 0, "R6", doneCnt, 0, "done when SDA held too long");
    check(byteCnt == 1, "R6", byteCnt, 1, "bytes before release timeout");
    repeat (400) @(negedge clk);
    check(!sclPullLow && !sdaPullLow, "R6", {sclPullLow, sdaPullLow}, 0, "lines after timeout");
  endtask

  initial begin
    repeat (5) @(negedge clk);
    testReset();
    rstN = 1'b1;
    repeat (5) @(negedge clk);
    testReset();
    testFullRun();
    testNoAck();
    testRestartClears();
    testSlowRelease();
    testStuckRelease();
    testBusyStart();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #(190000 * 10);
    compared++;
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule